// File: doc/BRIEF.md
# Integer 5/3 Lifting Inverse Reconstructor

This block rebuilds a frame of sixteen signed integer samples from the eight low-pass and eight high-pass coefficients of a reversible 5/3 lifting transform. Coefficients arrive one per clock. Each one is tagged as low or high and is stored in its own bank. When both banks are full, the block undoes the two lifting steps in the opposite order, with the opposite signs. First it removes the update contribution to recover every even-position sample. Then it adds back the prediction to recover every odd-position sample. At both frame ends it uses the same mirrored boundary rule as the forward side.

The recovered samples stream out one per clock in natural order (position 0 first), under a valid strobe. A one-cycle end-of-frame pulse accompanies the last sample. The result must match the integers that entered the forward transform exactly, so the block is usable in a lossless coding path.

Top module: `ilift53_inv`

## Requirements
- R1: While reset is high and in the first cycle after it, `samp_vld` and `frame_done` are 0. Reset also empties both coefficient banks, so a partly delivered frame is forgotten and the next frame is rebuilt correctly.
- R2: A coefficient is taken on a clock edge where `coef_vld` is 1 during the fill phase. With `coef_is_high` = 1 it goes to the high bank, and with 0 it goes to the low bank. Within each bank it takes the next index in arrival order, whatever the interleaving between the two kinds.
- R3: Once a bank holds 8 coefficients, further coefficients of that kind are ignored until the frame has been emitted.
- R4: Coefficients presented while the block is reconstructing or emitting are ignored.
- R5: Even sample x[2i] = L[i] - floor((H[i-1] + H[i] + 2) / 4), where H[-1] is taken as H[0].
- R6: Odd sample x[2i+1] = H[i] + floor((x[2i] + x[2i+2]) / 2), where x[16] is taken as x[14].
- R7: All eight even samples are computed before the first odd sample.
- R8: The 16 samples leave in order x[0]..x[15] on 16 consecutive cycles with `samp_vld` high. `samp_vld` is never high while coefficients can be accepted.
- R9: `frame_done` is high for exactly one cycle, the one carrying x[15].
- R10: For any 10-bit signed input frame, the output equals the forward-transform input bit-exactly.
- R11: A coefficient presented in the cycle after the `frame_done` cycle is accepted as the first coefficient of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coef_vld | input | 1 | Coefficient present this cycle |
| coef_is_high | input | 1 | 1 = high-pass coefficient, 0 = low-pass |
| coef_val | input | 12 | Signed coefficient value |
| samp_vld | output | 1 | Recovered sample valid |
| samp_val | output | 10 | Signed recovered sample |
| frame_done | output | 1 | Pulse with the last sample of a frame |

## Verification
The reconstruction is driven with frames of zeros, all-maximum, all-minimum and alternating maximum/minimum values. Zeros and constant extremes isolate the rounding offset and the mirrored edges. The alternating pattern pushes the high-pass coefficients to their widest range and exposes width or sign mistakes. Seeded random frames are delivered in three orders: interleaved, all-low-then-all-high, and all-low plus a surplus low then all-high. These orders separate correct per-bank indexing from ordering by arrival. Junk coefficients are injected during reconstruction and emission, and a partial frame is cut off by reset; both cases show whether stale or unwanted beats leak into later frames.

// File: rtl/ilift_pkg.sv
package ilift_pkg;
    parameter int SAMP_W = 10;
    parameter int COEF_W = SAMP_W + 2;
    parameter int WIDE_W = COEF_W + 2;
    parameter int HALF   = 8;
    parameter int FRAME  = 2 * HALF;
    parameter int IDX_W  = $clog2(HALF);
    parameter int POS_W  = IDX_W + 1;
    parameter int CNT_W  = IDX_W + 1;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    typedef struct packed {
        logic  is_high;
        coef_t val;
    } coef_beat_t;

    typedef enum logic [1:0] {PH_FILL, PH_EVEN, PH_ODD, PH_EMIT} phase_e;

    // remove the update contribution: low - floor((hl + hr + 2) / 4)
    function automatic samp_t undo_update(coef_t lo, coef_t hl, coef_t hr);
        wide_t acc;
        acc = wide_t'(hl) + wide_t'(hr) + wide_t'(2);
        return samp_t'(wide_t'(lo) - (acc >>> 2));
    endfunction

    // restore the prediction: high + floor((el + er) / 2)
    function automatic samp_t undo_predict(coef_t hi, samp_t el, samp_t er);
        wide_t acc;
        acc = wide_t'(el) + wide_t'(er);
        return samp_t'(wide_t'(hi) + (acc >>> 1));
    endfunction
endpackage

// File: rtl/ilift_coef_store.sv
module ilift_coef_store import ilift_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       accept_en,
    input  logic       clear,
    input  logic       beat_vld,
    input  coef_beat_t beat,
    output coef_t      lo_arr [HALF],
    output coef_t      hi_arr [HALF],
    output logic       full
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(HALF);

    logic [CNT_W-1:0] lo_cnt, hi_cnt;
    logic lo_take, hi_take;

    assign lo_take = accept_en && beat_vld && !beat.is_high && (lo_cnt < FULL_CNT);
    assign hi_take = accept_en && beat_vld &&  beat.is_high && (hi_cnt < FULL_CNT);
    assign full    = (lo_cnt == FULL_CNT) && (hi_cnt == FULL_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
            for (int k = 0; k < HALF; k++) begin
                lo_arr[k] <= '0;
                hi_arr[k] <= '0;
            end
        end else if (clear) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else begin
            if (lo_take) begin
                lo_arr[lo_cnt[IDX_W-1:0]] <= beat.val;
                lo_cnt <= lo_cnt + 1'b1;
            end
            if (hi_take) begin
                hi_arr[hi_cnt[IDX_W-1:0]] <= beat.val;
                hi_cnt <= hi_cnt + 1'b1;
            end
        end
    end

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!accept_en && !clear) |=> ($stable(lo_cnt) && $stable(hi_cnt)));
    // R11
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (lo_cnt == '0 && hi_cnt == '0));
    // R3
    bank_saturate_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_cnt == FULL_CNT && !clear) |=> (lo_cnt == FULL_CNT));
endmodule

// File: rtl/ilift_recon_core.sv
module ilift_recon_core import ilift_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  full,
    input  coef_t lo_arr [HALF],
    input  coef_t hi_arr [HALF],
    input  logic  emit_last,
    output logic  accept_en,
    output logic  clear,
    output logic  emit_start,
    output samp_t xs [FRAME]
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HALF - 1);

    phase_e           phase;
    logic [IDX_W-1:0] idx, idx_prev, idx_next;
    logic [POS_W-1:0] even_pos, odd_pos, right_pos;
    samp_t            even_val, odd_val;
    logic             start_q;

    always_comb begin
        idx_prev  = (idx == '0) ? idx : idx - 1'b1;
        idx_next  = idx + 1'b1;
        even_pos  = {idx, 1'b0};
        odd_pos   = {idx, 1'b1};
        right_pos = (idx == LAST_IDX) ? even_pos : {idx_next, 1'b0};
        even_val  = undo_update(lo_arr[idx], hi_arr[idx_prev], hi_arr[idx]);
        odd_val   = undo_predict(hi_arr[idx], xs[even_pos], xs[right_pos]);
    end

    assign accept_en  = (phase == PH_FILL);
    assign clear      = (phase == PH_EMIT) && emit_last;
    assign emit_start = start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_FILL;
            idx     <= '0;
            start_q <= 1'b0;
            for (int k = 0; k < FRAME; k++) xs[k] <= '0;
        end else begin
            start_q <= 1'b0;
            unique case (phase)
                PH_FILL: if (full) begin
                    phase <= PH_EVEN;
                    idx   <= '0;
                end
                PH_EVEN: begin
                    xs[even_pos] <= even_val;
                    if (idx == LAST_IDX) begin
                        phase <= PH_ODD;
                        idx   <= '0;
                    end else idx <= idx_next;
                end
                PH_ODD: begin
                    xs[odd_pos] <= odd_val;
                    if (idx == LAST_IDX) begin
                        phase   <= PH_EMIT;
                        start_q <= 1'b1;
                    end else idx <= idx_next;
                end
                PH_EMIT: if (emit_last) phase <= PH_FILL;
                default: phase <= PH_FILL;
            endcase
        end
    end

    // R7
    odd_after_even_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ODD && $past(phase) != PH_ODD) |->
        ($past(phase) == PH_EVEN && $past(idx) == LAST_IDX));
    // R4
    fill_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EVEN && $past(phase) == PH_FILL) |-> $past(full));
endmodule

// File: rtl/ilift_emitter.sv
module ilift_emitter import ilift_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  samp_t xs [FRAME],
    output logic  samp_vld,
    output samp_t samp_val,
    output logic  last
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME - 1);

    logic             busy;
    logic [POS_W-1:0] pos;

    assign samp_vld = busy;
    assign samp_val = busy ? xs[pos] : '0;
    assign last     = busy && (pos == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            pos  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            pos  <= '0;
        end else if (busy) begin
            if (last) busy <= 1'b0;
            else      pos  <= pos + 1'b1;
        end
    end

    // R9
    done_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        last |-> samp_vld);
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        last |=> !last);
    // R8
    burst_chk: assert property (@(posedge clk) disable iff (rst)
        (samp_vld && !last) |=> samp_vld);
endmodule

// File: rtl/ilift53_inv.sv
module ilift53_inv import ilift_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              coef_vld,
    input  logic              coef_is_high,
    input  logic [COEF_W-1:0] coef_val,
    output logic              samp_vld,
    output logic [SAMP_W-1:0] samp_val,
    output logic              frame_done
);
    coef_beat_t beat;
    coef_t      lo_arr [HALF];
    coef_t      hi_arr [HALF];
    samp_t      xs [FRAME];
    samp_t      samp_s;
    logic       full, accept_en, clear, emit_start, emit_last;

    assign beat.is_high = coef_is_high;
    assign beat.val     = coef_t'(coef_val);

    ilift_coef_store store_i (
        .clk(clk), .rst(rst), .accept_en(accept_en), .clear(clear),
        .beat_vld(coef_vld), .beat(beat),
        .lo_arr(lo_arr), .hi_arr(hi_arr), .full(full)
    );

    ilift_recon_core core_i (
        .clk(clk), .rst(rst), .full(full), .lo_arr(lo_arr), .hi_arr(hi_arr),
        .emit_last(emit_last), .accept_en(accept_en), .clear(clear),
        .emit_start(emit_start), .xs(xs)
    );

    ilift_emitter emit_i (
        .clk(clk), .rst(rst), .start(emit_start), .xs(xs),
        .samp_vld(samp_vld), .samp_val(samp_s), .last(emit_last)
    );

    assign samp_val   = samp_s;
    assign frame_done = emit_last;

    // R8
    emit_phase_chk: assert property (@(posedge clk) disable iff (rst)
        samp_vld |-> !accept_en);
endmodule

// File: tb/ilift53_inv_tb_top.sv
module ilift53_inv_tb_top;
    localparam int N  = 16;
    localparam int H  = 8;
    localparam int CW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic coef_vld = 1'b0;
    logic coef_is_high = 1'b0;
    logic [CW-1:0] coef_val = '0;
    logic samp_vld, frame_done;
    logic [9:0] samp_val;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int xin [N];
    int lo_c [H];
    int hi_c [H];

    always #2 clk = ~clk;

    ilift53_inv dut_i (
        .clk(clk), .rst(rst), .coef_vld(coef_vld), .coef_is_high(coef_is_high),
        .coef_val(coef_val), .samp_vld(samp_vld), .samp_val(samp_val),
        .frame_done(frame_done)
    );

    function automatic int fdiv(int a, int b);
        int q;
        q = a / b;
        if ((a % b != 0) && ((a < 0) != (b < 0))) q = q - 1;
        return q;
    endfunction

    // forward 5/3 lifting with mirrored ends; the bench reference for R5, R6, R10
    task automatic forward();
        for (int i = 0; i < H; i++) begin
            int right = (i == H - 1) ? xin[2*i] : xin[2*i+2];
            hi_c[i] = xin[2*i+1] - fdiv(xin[2*i] + right, 2);
        end
        for (int i = 0; i < H; i++) begin
            int left = (i == 0) ? hi_c[0] : hi_c[i-1];
            lo_c[i] = xin[2*i] + fdiv(left + hi_c[i] + 2, 4);
        end
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(bit hi, int v);
        @(negedge clk);
        if ($urandom_range(0, 3) == 0) begin
            coef_vld = 1'b0;
            @(negedge clk);
        end
        coef_vld = 1'b1;
        coef_is_high = hi;
        coef_val = CW'(v);
    endtask

    // mode 0: interleaved, 1: lows then highs, 2: lows, surplus low, highs (R2, R3)
    task automatic send(int mode);
        if (mode == 0) begin
            for (int i = 0; i < H; i++) begin
                drive(1'b0, lo_c[i]);
                drive(1'b1, hi_c[i]);
            end
        end else begin
            for (int i = 0; i < H; i++) drive(1'b0, lo_c[i]);
            if (mode == 2) drive(1'b0, 1234);
            for (int i = 0; i < H; i++) drive(1'b1, hi_c[i]);
        end
    endtask

    task automatic collect(bit junk);
        int  pos = 0;
        bit  started = 0;
        bit  got = 0;
        for (int cyc = 0; cyc < 120 && !got; cyc++) begin
            @(negedge clk);
            if (samp_vld) begin
                started = 1;
                if (pos < N)
                    check($signed(samp_val) == xin[pos], "R10/R8 sample", $signed(samp_val), xin[pos]);
                if (frame_done) begin
                    check(pos == N - 1, "R9 done position", pos, N - 1);
                    got = 1;
                end
                pos++;
            end else begin
                if (started) check(1'b0, "R8 burst gap", pos, N);
                check(!frame_done, "R9 done without valid", 1, 0);
            end
            if (junk && !got) begin
                coef_vld = 1'b1;
                coef_is_high = 1'($urandom_range(0, 1));
                coef_val = CW'($urandom_range(0, 4095));
            end else coef_vld = 1'b0;
        end
        if (!got) check(1'b0, "R8 frame never completed", pos, N);
    endtask

    task automatic run(int mode, bit junk);
        forward();
        send(mode);
        collect(junk);
    endtask

    initial begin
        void'($urandom(32'h51ee7));
        repeat (3) @(negedge clk);
        check(samp_vld == 0, "R1 samp_vld in reset", int'(samp_vld), 0);
        check(frame_done == 0, "R1 frame_done in reset", int'(frame_done), 0);
        rst = 1'b0;
        @(negedge clk);
        check(samp_vld == 0, "R1 samp_vld after reset", int'(samp_vld), 0);

        for (int i = 0; i < N; i++) xin[i] = 0;
        run(0, 0);
        for (int i = 0; i < N; i++) xin[i] = 511;
        run(1, 0);
        for (int i = 0; i < N; i++) xin[i] = -512;
        run(0, 0);
        for (int i = 0; i < N; i++) xin[i] = (i % 2 == 0) ? 511 : -512;
        run(0, 1);
        for (int i = 0; i < N; i++) xin[i] = (i % 2 == 0) ? -512 : 511;
        run(2, 0);
        for (int i = 0; i < N; i++) xin[i] = i * 60 - 480;
        run(1, 1);

        // R5 R6 R10 R11: random frames, back to back, all three orders, junk on some (R4)
        for (int f = 0; f < 24; f++) begin
            for (int i = 0; i < N; i++) xin[i] = int'($urandom_range(0, 1023)) - 512;
            run(f % 3, f[0]);
        end

        // R1: partial frame cut by reset must be forgotten
        for (int i = 0; i < N; i++) xin[i] = 100 - i * 13;
        forward();
        drive(1'b0, 77);
        drive(1'b1, -55);
        drive(1'b0, 9);
        @(negedge clk);
        coef_vld = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        send(0);
        collect(0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule